// File: doc/BRIEF.md
# Multi-channel coarse-fine time stamping core

The core timestamps hits on several channels against a common start. A common start edge arms the core and clears a coarse counter. From then on the counter advances once per reference clock period. When a channel hit edge arrives while the core is armed and the gate is high, a result word is formed. Its high bits hold the coarse count. Its low bits hold a fine code taken from an N-tap thermometer vector, which comes from a delay line locked to one clock period. The channel number sits above both fields. The word is written into a small shared event buffer. A common stop edge disarms the core until the next start.

Start, stop and each hit line pass through a two-flop synchroniser and a rising-edge detector before they act. The fine code is the index of the first zero tap, counted from tap 0, so a bubble higher in the pattern has no effect. The buffer is read through a valid/ready stream. An entry is removed only on a cycle where valid and ready are both high. While ready is low, the head word stays on the output unchanged. When an event finds the buffer full, the event is dropped and a sticky overflow pin is raised. Only reset clears it.

Top module: `tdc_core`

## Requirements
- R1: After reset, out_valid and overflow are both 0.
- R2: If a hit rises D clock cycles after the start rose (D >= 1), the recorded coarse value is D-1. A new start restarts the count from zero.
- R3: The coarse value saturates at 2^CW-1 and does not wrap.
- R4: The fine field is the index of the lowest tap that is 0, with tap 0 being the first delay tap. An all-ones vector gives NTAP-1. Set taps above the first zero are ignored.
- R5: The result word is {channel[CHW-1:0], coarse[CW-1:0], fine[FB-1:0]}, with fine in the least significant bits and FB = log2(NTAP).
- R6: A hit is recorded only while the core is armed and gate is 1. A hit after reset with no start, or a hit with gate 0, leaves the buffer empty.
- R7: A stop edge disarms the core, so later hits are ignored until the next start. A stop while disarmed has no effect on a following start-and-hit measurement.
- R8: When hits on several channels rise in the same cycle, only the lowest-numbered channel is recorded.
- R9: Words leave the buffer in arrival order, one per cycle where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_data is held stable.
- R10: An event that arrives while the buffer holds DEPTH words is dropped. overflow then goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one coarse unit per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | Common start, asynchronous, acts on its rising edge |
| stop_in | input | 1 | Common stop, asynchronous, acts on its rising edge |
| gate | input | 1 | Hits are accepted only while high |
| hit | input | NCH | Per-channel hit strobes, asynchronous, act on rising edges |
| taps | input | NTAP | Thermometer vector from the locked delay line |
| out_valid | output | 1 | Buffer head word is present |
| out_ready | input | 1 | Consumer accepts the head word |
| out_data | output | CHW+CW+FB | Channel, coarse and fine fields |
| overflow | output | 1 | Sticky flag: an event was lost to a full buffer |

## Verification
The bench builds the core with NCH=4, NTAP=8, CW=5 and DEPTH=4. The narrow 5-bit counter lets a sweep of start-to-hit delays from 1 to 40 cycles cover the whole unsaturated range and run well past the saturation point. Along that sweep the bench rotates through every channel, every thermometer length and several bubbled patterns. The four-entry buffer can be filled in a few measurements, so the back-pressure hold, the arrival order and the sticky overflow on a fifth event are all checked directly.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic { ST_IDLE = 1'b0, ST_ARMED = 1'b1 } arm_t;
endpackage

// File: rtl/tdc_sync_edge.sv
module tdc_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
  parameter int NTAP = 8,
  localparam int FB = $clog2(NTAP)
) (
  input  logic [NTAP-1:0] taps,
  output logic [FB-1:0]   code
);
  always_comb begin
    code = FB'(NTAP - 1);
    for (int i = NTAP - 1; i >= 0; i--) begin
      if (!taps[i]) code = FB'(i);
    end
  end
endmodule

// File: rtl/tdc_fifo.sv
module tdc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_wr, do_rd;

  assign full      = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign out_valid = (wptr != rptr);
  assign do_wr     = push && !full;
  assign do_rd     = out_valid && out_ready;
  assign out_data  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_core.sv
module tdc_core
  import tdc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NTAP  = 8,
  parameter int CW    = 16,
  parameter int DEPTH = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int FB   = $clog2(NTAP),
  localparam int W    = CHW + CW + FB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_in,
  input  logic            stop_in,
  input  logic            gate,
  input  logic [NCH-1:0]  hit,
  input  logic [NTAP-1:0] taps,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data,
  output logic            overflow
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [NCH+1:0] rises;
  logic           start_rise, stop_rise;
  logic [NCH-1:0] hit_rise, hit_ok;
  arm_t           state;
  logic           armed;
  logic [CW-1:0]  coarse;
  logic [FB-1:0]  fine;
  logic [CHW-1:0] ch_sel;
  logic           any_hit;
  logic           cap_valid;
  logic [W-1:0]   cap_word;
  logic           fifo_full;

  tdc_sync_edge #(.W(NCH + 2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({hit, stop_in, start_in}),
    .rise(rises)
  );

  assign start_rise = rises[0];
  assign stop_rise  = rises[1];
  assign hit_rise   = rises[NCH+1:2];
  assign armed      = (state == ST_ARMED);
  assign hit_ok     = hit_rise & {NCH{armed && gate}};

  tdc_therm_enc #(.NTAP(NTAP)) u_enc (.taps(taps), .code(fine));

  always_comb begin
    ch_sel  = '0;
    any_hit = |hit_ok;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit_ok[i]) ch_sel = CHW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      coarse <= '0;
    end else if (start_rise) begin
      state  <= ST_ARMED;
      coarse <= '0;
    end else if (stop_rise) begin
      state  <= ST_IDLE;
    end else if (armed && coarse != CMAX) begin
      coarse <= coarse + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_word  <= '0;
      overflow  <= 1'b0;
    end else begin
      cap_valid <= any_hit;
      if (any_hit) cap_word <= {ch_sel, coarse, fine};
      if (cap_valid && fifo_full) overflow <= 1'b1;
    end
  end

  tdc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(cap_valid), .din(cap_word), .full(fifo_full),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/tdc_core_chk.sv
module tdc_core_chk #(
  parameter int CW = 16,
  parameter int W  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          overflow,
  input logic          armed,
  input logic          start_rise,
  input logic          stop_rise,
  input logic [CW-1:0] coarse,
  input logic          cap_valid,
  input logic          fifo_full
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_drop_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && fifo_full |=> overflow);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_rise && coarse == CMAX |=> coarse == CMAX);

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_rise && !stop_rise && coarse != CMAX |=> coarse == CW'($past(coarse) + 1'b1));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_rise |=> armed && coarse == '0);
endmodule

bind tdc_core tdc_core_chk #(.CW(CW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .overflow(overflow), .armed(armed),
  .start_rise(start_rise), .stop_rise(stop_rise), .coarse(coarse),
  .cap_valid(cap_valid), .fifo_full(fifo_full)
);

// File: tb/tdc_core_tb.sv
module tdc_core_tb;
  localparam int NCH = 4, NTAP = 8, CW = 5, DEPTH = 4;
  localparam int CHW = 2, FB = 3, W = CHW + CW + FB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_in = 1'b0, stop_in = 1'b0, gate = 1'b1, out_ready = 1'b0;
  logic [NCH-1:0] hit = '0;
  logic [NTAP-1:0] taps = '0;
  logic out_valid, overflow;
  logic [W-1:0] out_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tdc_core #(.NCH(NCH), .NTAP(NTAP), .CW(CW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .stop_in(stop_in),
    .gate(gate), .hit(hit), .taps(taps), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .overflow(overflow)
  );

  function automatic int exp_fine(logic [7:0] t);
    for (int i = 0; i < 8; i++) if (!t[i]) return i;
    return 7;
  endfunction

  function automatic logic [W-1:0] mk(int ch, int d, logic [7:0] t);
    int c;
    c = (d - 1 > 31) ? 31 : d - 1;
    return {CHW'(ch), CW'(c), FB'(exp_fine(t))};
  endfunction

  function automatic logic [7:0] pat(int k);
    if (k <= 8) return 8'((9'd1 << k) - 9'd1);
    return 8'((8'd1 << (k - 8)) - 8'd1) | 8'hA0;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic stim(input bit do_start, input int d, input logic [NCH-1:0] mask, input logic [7:0] tp);
    taps = tp;
    for (int c = 0; c < d + 4; c++) begin
      @(negedge clk);
      start_in = do_start && (c < 2);
      hit = (c >= d && c < d + 2) ? mask : '0;
    end
    @(negedge clk);
    start_in = 1'b0;
    hit = '0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_in = 1'b1;
    repeat (2) @(negedge clk);
    stop_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_word(input string tag, input logic [W-1:0] expv);
    int n = 0;
    while (!out_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check({tag, " valid"}, W'(out_valid), W'(1));
    check(tag, out_data, expv);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    check(tag, W'(out_valid), W'(0));
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 overflow", W'(overflow), W'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    stim(1'b0, 3, 4'b0001, 8'h0F);
    expect_empty("R6 hit without start");

    for (int d = 1; d <= 40; d++) begin
      stim(1'b1, d, NCH'(1 << (d % NCH)), pat(d % 12));
      expect_word((d > 32) ? "R3 saturation" : "R2 R4 R5 sweep",
                  mk(d % NCH, d, pat(d % 12)));
    end

    gate = 1'b0;
    stim(1'b1, 4, 4'b0100, 8'h07);
    expect_empty("R6 gate low");
    gate = 1'b1;

    stim(1'b1, 3, 4'b0000, 8'h0F);
    pulse_stop();
    stim(1'b0, 3, 4'b0010, 8'h0F);
    expect_empty("R7 hit after stop");
    pulse_stop();
    stim(1'b1, 5, 4'b0100, 8'h0F);
    expect_word("R7 stop while idle", mk(2, 5, 8'h0F));

    stim(1'b1, 6, 4'b1010, 8'h3F);
    expect_word("R8 lowest channel", mk(1, 6, 8'h3F));
    expect_empty("R8 single word");

    for (int d = 2; d <= 6; d++) stim(1'b1, d, 4'b0001, 8'h0F);
    check("R10 overflow set", W'(overflow), W'(1));
    held = out_data;
    repeat (3) @(negedge clk);
    check("R9 hold valid", W'(out_valid), W'(1));
    check("R9 hold data", out_data, held);
    for (int d = 2; d <= 5; d++) expect_word("R9 order", mk(0, d, 8'h0F));
    expect_empty("R10 fifth dropped");
    check("R10 overflow sticky", W'(overflow), W'(1));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule